// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block holds instructions that are ready to execute, grouped by operation class. Each held entry carries a sequence number (smaller means older) and a squashed flag. Every cycle the block looks at the oldest entry of each class. It visits the classes from the one with the oldest head to the one with the youngest head. It issues at most a configured number of instructions per cycle, and a class can issue only when its functional unit is free.

Each class has one functional unit with its own latency and its own pipelined or non-pipelined behaviour. An issued instruction appears on the execute output that many cycles after the issue decision. Results that arrive in the same cycle are packed into the low lanes, oldest first. An upstream stage inserts at most one ready instruction per cycle. A squash request marks every held entry younger than a given sequence number. Squashed entries are dropped when they reach the head of their class.

Top module: `iss_age_select`

## Requirements
- R1: After reset no class holds an entry, and `cls_full`, `fu_skip` and `ex_valid` are all zero.
- R2: When `ins_valid` is high, the entry (`ins_seq`) is stored in class `ins_cls`, a binary class index, and becomes eligible from the next cycle. The insert is ignored if that class already held SLOTS entries at the start of the cycle. `cls_full[c]` is high exactly while class c holds SLOTS entries.
- R3: Within a class the held entry with the smallest sequence number is always the one considered. This also holds when an entry older than the current head is inserted later.
- R4: In each cycle the classes whose head is not squashed are visited in ascending order of head sequence number. At most W instructions issue per cycle, and each class issues at most one. Visiting stops once W have issued.
- R5: When `sq_valid` is high, every entry held at that time with a sequence number greater than `sq_seq` is marked squashed. The insert of the same cycle is not marked. A squashed head is removed in the cycle it is considered. It does not count toward W, it never reaches the execute output, and its class issues nothing in that cycle.
- R6: A visited class whose unit is busy does not issue, keeps its head, and raises `fu_skip[c]` for that cycle. Classes not visited because W was already reached raise no flag.
- R7: An instruction of class c chosen in cycle t appears on the execute output in cycle t+LAT(c). A single-cycle class therefore shows its result in the next cycle.
- R8: A non-pipelined unit with latency L > 1 stays busy for the L-1 cycles after an issue. A pipelined unit can accept an issue every cycle.
- R9: Results due in the same cycle occupy lanes 0 upward in ascending sequence order, and unused upper lanes read invalid. Lane i occupies `ex_seq[i*SW +: SW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert one ready entry this cycle |
| ins_cls | input | CLW (2) | Class index of the inserted entry |
| ins_seq | input | SW (16) | Sequence number of the inserted entry |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SW (16) | Entries younger than this are marked squashed |
| cls_full | output | NC (4) | Per-class full indication |
| fu_skip | output | NC (4) | Class visited this cycle but its unit was busy |
| ex_valid | output | NC (4) | Execute lane valid, packed from lane 0 |
| ex_seq | output | NC*SW (64) | Execute lane sequence numbers, oldest in lane 0 |

## Verification
The selection outcome (`fu_skip`) and `cls_full` depend only on registered state, so they are due in the same cycle as the state that causes them. An insert or squash takes effect one edge later. A result of class c is due exactly LAT(c) cycles after the cycle in which it was chosen. The reference model tags each chosen instruction with that due cycle and expects it in precisely that cycle, no earlier and no later. All outputs are sampled on the falling edge, after the state for the current cycle has settled and before the next inputs are applied.

// File: rtl/iss_pkg.sv
package iss_pkg;

  // outcome of one class in one selection cycle
  typedef enum logic [1:0] {
    SEL_IDLE    = 2'd0,
    SEL_DISCARD = 2'd1,
    SEL_ISSUE   = 2'd2,
    SEL_SKIP    = 2'd3
  } sel_kind_e;

  // age comparison: smaller sequence is older, ties go to the lower index
  function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b,
                                     input int ia, input int ib);
    return (a < b) || ((a == b) && (ia < ib));
  endfunction

endpackage

// File: rtl/iss_class_bank.sv
module iss_class_bank #(
  parameter int SLOTS = 8,
  parameter int SW    = 16,
  localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_en,
  input  logic [SW-1:0] ins_seq,
  input  logic          sq_en,
  input  logic [SW-1:0] sq_seq,
  input  logic          pop,
  output logic          head_v,
  output logic [SW-1:0] head_seq,
  output logic          head_sq,
  output logic          full
);

  logic [SLOTS-1:0]         vld;
  logic [SLOTS-1:0]         sqf;
  logic [SLOTS-1:0][SW-1:0] seqs;
  logic [IW-1:0]            head_idx;
  logic [IW-1:0]            free_idx;
  logic                     free_found;

  // oldest held entry and lowest empty slot
  always_comb begin
    head_v   = 1'b0;
    head_idx = '0;
    head_seq = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i] && (!head_v || (seqs[i] < head_seq))) begin
        head_v   = 1'b1;
        head_idx = IW'(i);
        head_seq = seqs[i];
      end
    end
    head_sq    = head_v & sqf[head_idx];
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end

  assign full = &vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      sqf  <= '0;
      seqs <= '0;
    end else begin
      if (pop) vld[head_idx] <= 1'b0;
      if (sq_en) begin
        for (int i = 0; i < SLOTS; i++) begin
          if (vld[i] && (seqs[i] > sq_seq)) sqf[i] <= 1'b1;
        end
      end
      if (ins_en && free_found) begin
        vld[free_idx]  <= 1'b1;
        seqs[free_idx] <= ins_seq;
        sqf[free_idx]  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/iss_fu_unit.sv
module iss_fu_unit #(
  parameter int SW   = 16,
  parameter int LAT  = 1,
  parameter bit PIPE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [SW-1:0] issue_seq,
  output logic          free,
  output logic          done_v,
  output logic [SW-1:0] done_seq
);

  logic [LAT-1:0]         stg_v;
  logic [LAT-1:0][SW-1:0] stg_s;

  // result delay line, one stage per cycle of latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v <= '0;
      stg_s <= '0;
    end else begin
      stg_v[0] <= issue;
      stg_s[0] <= issue_seq;
      for (int k = 1; k < LAT; k++) begin
        stg_v[k] <= stg_v[k-1];
        stg_s[k] <= stg_s[k-1];
      end
    end
  end

  assign done_v   = stg_v[LAT-1];
  assign done_seq = stg_s[LAT-1];

  generate
    if (PIPE || (LAT == 1)) begin : g_pipe
      assign free = 1'b1;
    end else begin : g_hold
      localparam int CW = $clog2(LAT);
      logic [CW-1:0] hold;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hold <= '0;
        else if (issue)        hold <= CW'(LAT - 1);
        else if (hold != '0)   hold <= hold - 1'b1;
      end
      assign free = (hold == '0);
    end
  endgenerate

endmodule

// File: rtl/iss_pick.sv
module iss_pick
  import iss_pkg::*;
#(
  parameter int NC = 4,
  parameter int W  = 2,
  parameter int SW = 16
) (
  input  logic [NC-1:0]         head_v,
  input  logic [NC-1:0]         head_sq,
  input  logic [NC-1:0][SW-1:0] head_seq,
  input  logic [NC-1:0]         fu_free,
  output sel_kind_e             kind [NC]
);

  logic [NC-1:0] cand;
  assign cand = head_v & ~head_sq;

  // number of older candidate classes that take an issue slot ahead of class c
  function automatic int issued_ahead(input int c, input logic [NC-1:0] cv,
                                      input logic [NC-1:0] fr,
                                      input logic [NC-1:0][SW-1:0] sq);
    int n = 0;
    for (int d = 0; d < NC; d++) begin
      if ((d != c) && cv[d] && fr[d] && seq_older(32'(sq[d]), 32'(sq[c]), d, c)) n++;
    end
    return n;
  endfunction

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      if (!head_v[c])                                   kind[c] = SEL_IDLE;
      else if (head_sq[c])                              kind[c] = SEL_DISCARD;
      else if (issued_ahead(c, cand, fu_free, head_seq) >= W) kind[c] = SEL_IDLE;
      else if (fu_free[c])                              kind[c] = SEL_ISSUE;
      else                                              kind[c] = SEL_SKIP;
    end
  end

endmodule

// File: rtl/iss_exec_pack.sv
module iss_exec_pack #(
  parameter int NC = 4,
  parameter int SW = 16
) (
  input  logic [NC-1:0]         done_v,
  input  logic [NC-1:0][SW-1:0] done_seq,
  output logic [NC-1:0]         lane_v,
  output logic [NC-1:0][SW-1:0] lane_seq
);

  // lane of result c: count of valid results older than it
  function automatic int lane_rank(input int c, input logic [NC-1:0] v,
                                   input logic [NC-1:0][SW-1:0] s);
    int r = 0;
    for (int d = 0; d < NC; d++) begin
      if ((d != c) && v[d] && iss_pkg::seq_older(32'(s[d]), 32'(s[c]), d, c)) r++;
    end
    return r;
  endfunction

  always_comb begin
    lane_v   = '0;
    lane_seq = '0;
    for (int c = 0; c < NC; c++) begin
      if (done_v[c]) begin
        lane_v[lane_rank(c, done_v, done_seq)]   = 1'b1;
        lane_seq[lane_rank(c, done_v, done_seq)] = done_seq[c];
      end
    end
  end

endmodule

// File: rtl/iss_age_select.sv
module iss_age_select
  import iss_pkg::*;
#(
  parameter int NC    = 4,
  parameter int SLOTS = 8,
  parameter int W     = 2,
  parameter int SW    = 16,
  parameter int LAT_W = 4,
  parameter logic [NC*LAT_W-1:0] LAT_VEC  = {4'd2, 4'd4, 4'd3, 4'd1},
  parameter logic [NC-1:0]       PIPE_VEC = 4'b0011,
  localparam int CLW = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [CLW-1:0]   ins_cls,
  input  logic [SW-1:0]    ins_seq,
  input  logic             sq_valid,
  input  logic [SW-1:0]    sq_seq,
  output logic [NC-1:0]    cls_full,
  output logic [NC-1:0]    fu_skip,
  output logic [NC-1:0]    ex_valid,
  output logic [NC*SW-1:0] ex_seq
);

  logic [NC-1:0]         head_v;
  logic [NC-1:0]         head_sq;
  logic [NC-1:0][SW-1:0] head_seq;
  logic [NC-1:0]         fu_free;
  logic [NC-1:0]         done_v;
  logic [NC-1:0][SW-1:0] done_seq;
  logic [NC-1:0][SW-1:0] lane_seq;
  sel_kind_e             kind [NC];

  // named selection events
  logic [NC-1:0] iss_vec;
  logic [NC-1:0] disc_vec;
  logic [NC-1:0] skip_vec;

  generate
    for (genvar c = 0; c < NC; c++) begin : g_cls
      assign iss_vec[c]  = (kind[c] == SEL_ISSUE);
      assign disc_vec[c] = (kind[c] == SEL_DISCARD);
      assign skip_vec[c] = (kind[c] == SEL_SKIP);

      iss_class_bank #(.SLOTS(SLOTS), .SW(SW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (ins_valid && (ins_cls == CLW'(c))),
        .ins_seq  (ins_seq),
        .sq_en    (sq_valid),
        .sq_seq   (sq_seq),
        .pop      (iss_vec[c] | disc_vec[c]),
        .head_v   (head_v[c]),
        .head_seq (head_seq[c]),
        .head_sq  (head_sq[c]),
        .full     (cls_full[c])
      );

      iss_fu_unit #(
        .SW   (SW),
        .LAT  (int'(LAT_VEC[c*LAT_W +: LAT_W])),
        .PIPE (PIPE_VEC[c])
      ) u_fu (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (iss_vec[c]),
        .issue_seq (head_seq[c]),
        .free      (fu_free[c]),
        .done_v    (done_v[c]),
        .done_seq  (done_seq[c])
      );
    end
  endgenerate

  iss_pick #(.NC(NC), .W(W), .SW(SW)) u_pick (
    .head_v   (head_v),
    .head_sq  (head_sq),
    .head_seq (head_seq),
    .fu_free  (fu_free),
    .kind     (kind)
  );

  iss_exec_pack #(.NC(NC), .SW(SW)) u_pack (
    .done_v   (done_v),
    .done_seq (done_seq),
    .lane_v   (ex_valid),
    .lane_seq (lane_seq)
  );

  assign fu_skip = skip_vec;
  assign ex_seq  = lane_seq;

endmodule

// File: rtl/iss_age_select_chk.sv
module iss_age_select_chk #(
  parameter int NC    = 4,
  parameter int W     = 2,
  parameter int SW    = 16,
  parameter int LAT_W = 4,
  parameter logic [NC*LAT_W-1:0] LAT_VEC  = {4'd2, 4'd4, 4'd3, 4'd1},
  parameter logic [NC-1:0]       PIPE_VEC = 4'b0011
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NC-1:0]    iss_vec,
  input logic [NC-1:0]    ex_valid,
  input logic [NC*SW-1:0] ex_seq
);

  // R4: issue width cap
  a_r4_width_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(iss_vec) <= W);

  generate
    for (genvar c = 0; c < NC; c++) begin : g_c
      localparam int L = int'(LAT_VEC[c*LAT_W +: LAT_W]);
      if (!PIPE_VEC[c] && (L > 1)) begin : g_np
        // R8: non-pipelined unit cannot take back-to-back issues
        a_r8_np_hold: assert property (@(posedge clk) disable iff (!rst_n)
          iss_vec[c] |=> !iss_vec[c]);
      end
      if (L == 1) begin : g_l1
        // R7: single-cycle result shows up on the next cycle
        a_r7_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
          iss_vec[c] |=> ex_valid[0]);
      end
    end
    for (genvar i = 0; i + 1 < NC; i++) begin : g_lane
      // R9: lanes packed from zero, ascending age order
      a_r9_packed: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid[i+1] |-> ex_valid[i]);
      a_r9_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid[i+1] |-> (ex_seq[i*SW +: SW] < ex_seq[(i+1)*SW +: SW]));
    end
  endgenerate

endmodule

bind iss_age_select iss_age_select_chk #(
  .NC(NC), .W(W), .SW(SW), .LAT_W(LAT_W), .LAT_VEC(LAT_VEC), .PIPE_VEC(PIPE_VEC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .iss_vec  (iss_vec),
  .ex_valid (ex_valid),
  .ex_seq   (ex_seq)
);

// File: tb/iss_age_select_test.sv
`timescale 1ns/1ps
module iss_age_select_test;
  localparam int NC = 4, SLOTS = 8, W = 2, SW = 16;
  localparam int LATC [NC] = '{1, 3, 4, 2};
  localparam bit PIPEC [NC] = '{1'b1, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, sq_valid = 1'b0;
  logic [1:0] ins_cls = '0;
  logic [SW-1:0] ins_seq = '0, sq_seq = '0;
  logic [NC-1:0] cls_full, fu_skip, ex_valid;
  logic [NC*SW-1:0] ex_seq;

  always #10 clk = ~clk;

  iss_age_select #(.NC(NC), .SLOTS(SLOTS), .W(W), .SW(SW), .LAT_W(4),
                   .LAT_VEC({4'd2, 4'd4, 4'd3, 4'd1}), .PIPE_VEC(4'b0011)) uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_cls(ins_cls),
    .ins_seq(ins_seq), .sq_valid(sq_valid), .sq_seq(sq_seq),
    .cls_full(cls_full), .fu_skip(fu_skip), .ex_valid(ex_valid), .ex_seq(ex_seq));

  int tests = 0, fails = 0, cyc_n = 0;
  bit done = 1'b0;

  // reference model state
  bit mv [NC][SLOTS];
  int ms [NC][SLOTS];
  bit mq [NC][SLOTS];
  int mb [NC];
  int pq_seq[$];
  int pq_due[$];
  int hidx [NC];
  int kind [NC];   // 0 none, 1 drop, 2 issue, 3 busy skip

  function automatic int held(int c);
    int n = 0;
    for (int i = 0; i < SLOTS; i++) if (mv[c][i]) n++;
    return n;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d act=%0d exp=%0d", what, cyc_n, act, exp);
    end
  endtask

  task automatic mdl_eval();
    bit seen [NC];
    int issued = 0;
    for (int c = 0; c < NC; c++) begin
      hidx[c] = -1; kind[c] = 0; seen[c] = 1'b0;
      for (int i = 0; i < SLOTS; i++)
        if (mv[c][i] && (hidx[c] < 0 || ms[c][i] < ms[c][hidx[c]])) hidx[c] = i;
      if (hidx[c] >= 0 && mq[c][hidx[c]]) kind[c] = 1;
    end
    for (int k = 0; k < NC; k++) begin
      int best = -1;
      for (int c = 0; c < NC; c++)
        if (hidx[c] >= 0 && kind[c] != 1 && !seen[c] &&
            (best < 0 || ms[c][hidx[c]] < ms[best][hidx[best]])) best = c;
      if (best >= 0 && issued < W) begin
        seen[best] = 1'b1;
        if (mb[best] == 0) begin kind[best] = 2; issued++; end
        else kind[best] = 3;
      end
    end
  endtask

  task automatic compare(string tag);
    int ev [$];
    int expv = 0, actv = 0;
    for (int j = pq_due.size() - 1; j >= 0; j--)
      if (pq_due[j] == cyc_n) begin ev.push_back(pq_seq[j]); pq_due.delete(j); pq_seq.delete(j); end
    ev.sort();
    for (int j = 0; j < ev.size(); j++) expv |= (1 << j);
    actv = int'(ex_valid);
    chk(actv == expv, {tag, " R7 R9 ex_valid"}, actv, expv);
    for (int j = 0; j < ev.size(); j++)
      chk(int'(ex_seq[j*SW +: SW]) == ev[j], {tag, " R3 R4 R9 lane seq"},
          int'(ex_seq[j*SW +: SW]), ev[j]);
    begin
      int es = 0, ef = 0;
      for (int c = 0; c < NC; c++) begin
        if (kind[c] == 3) es |= (1 << c);
        if (held(c) == SLOTS) ef |= (1 << c);
      end
      chk(int'(fu_skip) == es, {tag, " R6 R8 fu_skip"}, int'(fu_skip), es);
      chk(int'(cls_full) == ef, {tag, " R2 cls_full"}, int'(cls_full), ef);
    end
  endtask

  task automatic mdl_commit(bit iv, int ic, int is, bit sv, int ss);
    bit fullpre = (held(ic) == SLOTS);
    for (int c = 0; c < NC; c++) begin
      if (kind[c] == 1 || kind[c] == 2) mv[c][hidx[c]] = 1'b0;
      if (mb[c] > 0) mb[c]--;
      if (kind[c] == 2) begin
        pq_seq.push_back(ms[c][hidx[c]]);
        pq_due.push_back(cyc_n + LATC[c]);
        if (!PIPEC[c] && LATC[c] > 1) mb[c] = LATC[c] - 1;
      end
    end
    if (sv)
      for (int c = 0; c < NC; c++)
        for (int i = 0; i < SLOTS; i++)
          if (mv[c][i] && ms[c][i] > ss) mq[c][i] = 1'b1;
    if (iv && !fullpre) begin
      int slot = -1;
      for (int i = SLOTS - 1; i >= 0; i--) if (!mv[ic][i]) slot = i;
      mv[ic][slot] = 1'b1; ms[ic][slot] = is; mq[ic][slot] = 1'b0;
    end
  endtask

  task automatic cyc(bit iv, int ic, int is, bit sv, int ss, string tag);
    @(negedge clk);
    mdl_eval();
    compare(tag);
    mdl_commit(iv, ic, is, sv, ss);
    ins_valid = iv; ins_cls = ic[1:0]; ins_seq = is[SW-1:0];
    sq_valid = sv; sq_seq = ss[SW-1:0];
    @(posedge clk);
    cyc_n++;
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int hi = 1000, lo = 999;
    int st = 32'h1234_5678;
    for (int c = 0; c < NC; c++) begin
      mb[c] = 0;
      for (int i = 0; i < SLOTS; i++) begin mv[c][i] = 0; ms[c][i] = 0; mq[c][i] = 0; end
    end
    repeat (3) @(negedge clk);
    // R1: idle outputs while in reset
    chk(ex_valid == '0, "R1 reset ex_valid", int'(ex_valid), 0);
    chk(fu_skip == '0, "R1 reset fu_skip", int'(fu_skip), 0);
    chk(cls_full == '0, "R1 reset cls_full", int'(cls_full), 0);
    rst_n = 1'b1;
    // R3 R4: cross-class age order, an older insert overtakes its class head
    cyc(1, 0, 150, 0, 0, "R1 R3 R4");
    cyc(1, 1, 140, 0, 0, "R3 R4");
    cyc(1, 3, 120, 0, 0, "R3 R4");
    cyc(1, 2, 130, 0, 0, "R3 R4");
    cyc(1, 0, 110, 0, 0, "R3 R4");
    cyc(1, 0, 105, 0, 0, "R3 R4");
    repeat (8) cyc(0, 0, 0, 0, 0, "R3 R4 drain");
    // R2: back up the non-pipelined class until it is full
    for (int k = 0; k < 14; k++) cyc(1, 2, 200 + k, 0, 0, "R2 fill");
    // R5: squash the younger half, squashed heads drop out
    cyc(1, 3, 300, 1, 204, "R5 squash");
    repeat (20) cyc(0, 0, 0, 0, 0, "R5 drain");
    // R6 R8: busy units against back-to-back inserts
    for (int k = 0; k < 6; k++) cyc(1, (k % 2 == 0) ? 3 : 2, 400 + k, 0, 0, "R6 R8 busy");
    repeat (10) cyc(0, 0, 0, 0, 0, "R6 R8 drain");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      bit iv, sv;
      int ic, is, ss;
      st = st ^ (st << 13); st = st ^ (st >>> 17); st = st ^ (st << 5);
      iv = st[0] | st[1];
      ic = int'(st[3:2]);
      if (st[6:4] == 3'd0) begin is = lo; lo--; end else begin is = hi; hi++; end
      sv = (st[11:8] == 4'd0);
      ss = hi - int'(st[14:12]);
      cyc(iv, ic, is, sv, ss, "R4 R6 R7 R9 mix");
    end
    repeat (20) cyc(0, 0, 0, 0, 0, "R7 R9 final");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule